// File: doc/BRIEF.md
# Two-Level Interrupt Controller with Fast-Interrupt Routing

This block gathers 32 main interrupt request lines and a smaller set of sub-source lines and presents them to a processor as two outputs. One output is a normal interrupt and the other is a fast interrupt. Each request line is either edge-style or level-style, chosen by a per-line strap input. A rising edge sets the line's pending bit. A falling edge clears that bit. A level-style line also re-sets its pending bit on every cycle for as long as it stays high. Sub-source pending bits pass through their own mask. They are then collapsed in groups of three onto three fixed main pending bits, so that several small requesters share one main slot.

Software controls the block through eight 32-bit word registers on a simple read/write bus. The pending registers are cleared by writing ones. The mask, mode, priority and sub-mask registers are plain storage. Unmasked main sources whose mode bit is set drive the fast-interrupt output. The lowest-numbered unmasked source is latched into a one-hot in-service register, and its index is latched into an index register. The normal interrupt output is high while the in-service register is non-zero. The priority register is stored and read back only; it takes no part in selection.

Evaluation runs once per clock from registered state. An input edge reaches the main pending register on the next clock edge and reaches the outputs one clock edge after that. A sub-source edge needs one more clock edge to pass through the folding stage.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: Register select is address bits [4:2]. The registers are: 0 main pending, 1 mode, 2 mask, 3 priority, 4 in-service (one-hot), 5 index, 6 sub pending, 7 sub-mask. After reset, mask reads 0xFFFFFFFF, priority reads 0x7F, sub-mask reads 0x7FF, and every other register reads 0. Both interrupt outputs are low after reset.
- R2: Writing to main pending, in-service or sub pending clears each bit that is 1 in the written word. Writing to mode, mask, priority or sub-mask replaces the whole word.
- R3: Writes to the index register (select 5) have no effect on its contents.
- R4: Unmasked sub pending bits fold onto main pending bits as follows: bits 0–2 set bit 28, bits 3–5 set bit 23, and bits 6–8 set bit 15. A sub pending bit that is masked, or that lies above bit 8, sets no main bit.
- R5: When any bit of (main pending AND NOT mask AND mode) is set, the fast-interrupt output is high. On such a pass the in-service and index registers do not change. When no such bit is set, the fast-interrupt output is low.
- R6: The candidate is the lowest-numbered bit of (main pending AND NOT mask). The candidate replaces the in-service register (one-hot), and its number goes into the index register, only when the in-service register is zero or numerically larger than the candidate. A higher-numbered candidate never displaces a lower one that is already latched.
- R7: The normal interrupt output is high exactly while the in-service register is non-zero. Whenever the in-service register is non-zero, it equals 1 shifted left by the index register.
- R8: A line whose level strap is 1 when it rises keeps its pending bit set on every cycle while it stays high, even through software clears. A falling edge on any line clears that line's pending bit.
- R9: If a line rises in the same cycle as a software write that clears the same pending bit, the bit ends up set.
- R10: A read strobe returns the selected register on the read-data output one clock later, with the read-valid output high for that single cycle.
- R11: An edge-style line sets its pending bit only on its rising edge. After a software clear, the bit stays clear while the line remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid one cycle after the strobe |
| bus_rvalid_o | output | 1 | High in the cycle that read data is valid |
| src_req_i | input | 32 | Main request lines |
| src_level_i | input | 32 | Per-line level-style strap for the main lines |
| sub_req_i | input | 11 | Sub-source request lines |
| sub_level_i | input | 11 | Per-line level-style strap for the sub lines |
| irq_o | output | 1 | Normal interrupt |
| fiq_o | output | 1 | Fast interrupt |

## Verification
The bench sweeps every main line and every sub line, and checks the one-hot in-service value, the index and the folded main bit against values it computes arithmetically. A wrong fold table would light the wrong main bit. The bench checks replacement ordering: a lower-numbered arrival displaces a latched request, a higher-numbered one does not, and clearing main pending before in-service lets the next source in. A design that compared in the wrong direction, or always overwrote, would show the wrong index. The bench also covers a fast source that freezes the in-service register, the level-style hold against a software clear, a set and a clear colliding on the same bit, and the read-only index register. Each of these fails visibly if the precedence or the hold logic is inverted.

// File: rtl/irq_cc_pkg.sv
package irq_cc_pkg;

  localparam int CC_DATA_W     = 32;
  localparam int CC_FOLD_GRPS  = 3;
  localparam int CC_FOLD_SPAN  = 3;

  typedef enum logic [2:0] {
    SEL_SRC_PEND  = 3'd0,
    SEL_MODE      = 3'd1,
    SEL_MASK      = 3'd2,
    SEL_PRIO      = 3'd3,
    SEL_INSVC     = 3'd4,
    SEL_INDEX     = 3'd5,
    SEL_SUB_PEND  = 3'd6,
    SEL_SUB_MASK  = 3'd7
  } reg_sel_e;

  localparam logic [CC_DATA_W-1:0] RST_MASK     = 32'hFFFF_FFFF;
  localparam logic [CC_DATA_W-1:0] RST_PRIO     = 32'h0000_007F;
  localparam logic [CC_DATA_W-1:0] RST_SUB_MASK = 32'h0000_07FF;

  // Main pending bit that a sub-source group collapses onto
  function automatic int fold_target(input int grp);
    case (grp)
      0:       return 28;
      1:       return 23;
      default: return 15;
    endcase
  endfunction

  // All main bits that folding may drive
  function automatic logic [CC_DATA_W-1:0] fold_bits();
    logic [CC_DATA_W-1:0] m;
    m = '0;
    for (int g = 0; g < CC_FOLD_GRPS; g++) m[fold_target(g)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_cc_input_track.sv
module irq_cc_input_track #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] req_q;
  logic [W-1:0] held_q;

  assign rise_o = req_i & ~req_q;
  assign fall_o = ~req_i & req_q;
  // A held line re-asserts its pending bit only while it is still high
  assign hold_o = held_q & req_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      held_q <= '0;
    end else begin
      req_q  <= req_i;
      held_q <= (held_q & req_i) | (rise_o & lvl_i);
    end
  end

  // R8: a remembered hold never outlives the input that created it
  assert_hold_follows_input_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((held_q & ~$past(req_i)) == '0));

endmodule

// File: rtl/irq_cc_fold.sv
module irq_cc_fold
  import irq_cc_pkg::*;
#(
  parameter int SUB_W = 11,
  parameter int SRC_W = 32
) (
  input  logic [SUB_W-1:0] sub_act_i,
  output logic [SRC_W-1:0] fold_o
);
  logic [CC_FOLD_GRPS-1:0] grp_hit;

  genvar g;
  generate
    for (g = 0; g < CC_FOLD_GRPS; g++) begin : g_grp
      assign grp_hit[g] = |sub_act_i[g*CC_FOLD_SPAN +: CC_FOLD_SPAN];
    end
  endgenerate

  always_comb begin
    fold_o = '0;
    for (int k = 0; k < CC_FOLD_GRPS; k++)
      if (grp_hit[k]) fold_o[fold_target(k)] = 1'b1;
  end

endmodule

// File: rtl/irq_cc_select.sv
module irq_cc_select #(
  parameter int SRC_W = 32,
  localparam int IDX_W = $clog2(SRC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] active_i,
  input  logic [SRC_W-1:0] mode_i,
  input  logic [SRC_W-1:0] clr_i,
  output logic [SRC_W-1:0] insvc_o,
  output logic [IDX_W-1:0] index_o,
  output logic             irq_o,
  output logic             fiq_o
);
  logic [SRC_W-1:0] insvc_q, insvc_d, kept, cand_oh;
  logic [IDX_W-1:0] index_q, index_d, cand_idx;
  logic             irq_q, fiq_q, fast;

  always_comb begin
    fast     = |(active_i & mode_i);
    // isolate lowest set bit
    cand_oh  = active_i & (~active_i + 1'b1);
    cand_idx = '0;
    for (int i = SRC_W - 1; i >= 0; i--)
      if (active_i[i]) cand_idx = IDX_W'(i);
    kept    = insvc_q & ~clr_i;
    insvc_d = kept;
    index_d = index_q;
    if (!fast && (active_i != '0) && ((kept == '0) || (kept > cand_oh))) begin
      insvc_d = cand_oh;
      index_d = cand_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      insvc_q <= '0;
      index_q <= '0;
      irq_q   <= 1'b0;
      fiq_q   <= 1'b0;
    end else begin
      insvc_q <= insvc_d;
      index_q <= index_d;
      irq_q   <= (insvc_d != '0);
      fiq_q   <= fast;
    end
  end

  assign insvc_o = insvc_q;
  assign index_o = index_q;
  assign irq_o   = irq_q;
  assign fiq_o   = fiq_q;

  assert_insvc_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(insvc_q));

  assert_index_matches_R7: assert property (@(posedge clk) disable iff (rst)
    (insvc_q != '0) |-> (insvc_q == (SRC_W'(1) << index_q)));

  assert_irq_tracks_insvc_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q == (insvc_q != '0));

  assert_fast_freezes_insvc_R5: assert property (@(posedge clk) disable iff (rst)
    fiq_q |-> ((insvc_q & ~$past(insvc_q)) == '0));

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cc_pkg::*;
#(
  parameter int SUB_W  = 11,
  parameter int ADDR_W = 5,
  localparam int DW    = CC_DATA_W,
  localparam int IDX_W = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             bus_rvalid_o,
  input  logic [DW-1:0]    src_req_i,
  input  logic [DW-1:0]    src_level_i,
  input  logic [SUB_W-1:0] sub_req_i,
  input  logic [SUB_W-1:0] sub_level_i,
  output logic             irq_o,
  output logic             fiq_o
);
  localparam logic [DW-1:0] FOLD_BITS = fold_bits();

  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr_i[4:2]);

  logic [DW-1:0]    src_pend_q, mode_q, mask_q, prio_q, sub_mask_q;
  logic [SUB_W-1:0] sub_pend_q;
  logic [DW-1:0]    rdata_q;
  logic             rvalid_q;

  logic [DW-1:0]    m_rise, m_fall, m_hold, fold_set;
  logic [SUB_W-1:0] s_rise, s_fall, s_hold;
  logic [DW-1:0]    wclr_src, wclr_insvc, src_pend_d;
  logic [SUB_W-1:0] wclr_sub, sub_pend_d;
  logic [DW-1:0]    insvc, sub_ext;
  logic [IDX_W-1:0] index;

  logic unused_bits;
  assign unused_bits = ^{bus_addr_i[1:0], sub_mask_q[DW-1:SUB_W]};

  irq_cc_input_track #(.W(DW)) u_main_trk (
    .clk(clk), .rst(rst), .req_i(src_req_i), .lvl_i(src_level_i),
    .rise_o(m_rise), .fall_o(m_fall), .hold_o(m_hold));

  irq_cc_input_track #(.W(SUB_W)) u_sub_trk (
    .clk(clk), .rst(rst), .req_i(sub_req_i), .lvl_i(sub_level_i),
    .rise_o(s_rise), .fall_o(s_fall), .hold_o(s_hold));

  irq_cc_fold #(.SUB_W(SUB_W), .SRC_W(DW)) u_fold (
    .sub_act_i(sub_pend_q & ~sub_mask_q[SUB_W-1:0]),
    .fold_o(fold_set));

  irq_cc_select #(.SRC_W(DW)) u_sel (
    .clk(clk), .rst(rst),
    .active_i(src_pend_q & ~mask_q),
    .mode_i(mode_q),
    .clr_i(wclr_insvc),
    .insvc_o(insvc), .index_o(index),
    .irq_o(irq_o), .fiq_o(fiq_o));

  // Clear masks from bus writes; sets from inputs are applied after them
  always_comb begin
    wclr_src   = (bus_wr_i && sel == SEL_SRC_PEND) ? bus_wdata_i : '0;
    wclr_insvc = (bus_wr_i && sel == SEL_INSVC)    ? bus_wdata_i : '0;
    wclr_sub   = (bus_wr_i && sel == SEL_SUB_PEND) ? bus_wdata_i[SUB_W-1:0] : '0;
    src_pend_d = (src_pend_q & ~wclr_src & ~m_fall) | m_rise | m_hold | fold_set;
    sub_pend_d = (sub_pend_q & ~wclr_sub & ~s_fall) | s_rise | s_hold;
    sub_ext    = '0;
    sub_ext[SUB_W-1:0] = sub_pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_pend_q <= '0;
      sub_pend_q <= '0;
      mode_q     <= '0;
      mask_q     <= RST_MASK;
      prio_q     <= RST_PRIO;
      sub_mask_q <= RST_SUB_MASK;
    end else begin
      src_pend_q <= src_pend_d;
      sub_pend_q <= sub_pend_d;
      if (bus_wr_i) begin
        case (sel)
          SEL_MODE:     mode_q     <= bus_wdata_i;
          SEL_MASK:     mask_q     <= bus_wdata_i;
          SEL_PRIO:     prio_q     <= bus_wdata_i;
          SEL_SUB_MASK: sub_mask_q <= bus_wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd_i;
      if (bus_rd_i) begin
        case (sel)
          SEL_SRC_PEND: rdata_q <= src_pend_q;
          SEL_MODE:     rdata_q <= mode_q;
          SEL_MASK:     rdata_q <= mask_q;
          SEL_PRIO:     rdata_q <= prio_q;
          SEL_INSVC:    rdata_q <= insvc;
          SEL_INDEX:    rdata_q <= DW'(index);
          SEL_SUB_PEND: rdata_q <= sub_ext;
          default:      rdata_q <= sub_mask_q;
        endcase
      end
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;

  assert_read_latency_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rd_i |=> bus_rvalid_o);

  assert_level_hold_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(m_hold) & ~src_pend_q) == '0));

  assert_fall_clears_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(m_fall) & src_pend_q & ~FOLD_BITS) == '0));

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(m_rise) & ~src_pend_q) == '0));

endmodule

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] src_req = '0, src_level = '0;
  logic [SW-1:0] sub_req = '0, sub_level = '0;
  logic        irq, fiq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cascade_ctrl #(.SUB_W(SW)) uut (
    .clk(clk), .rst(rst),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
    .src_req_i(src_req), .src_level_i(src_level),
    .sub_req_i(sub_req), .sub_level_i(sub_level),
    .irq_o(irq), .fiq_o(fiq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(sel << 2); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int sel, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 5'(sel << 2);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
    if (bus_rvalid !== 1'b1) chk("R10 rvalid", {31'b0, bus_rvalid}, 32'd1);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic int tgt(input int j);
    return (j < 3) ? 28 : (j < 6) ? 23 : 15;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq reset", {31'b0, irq}, 32'd0);
    chk("R1 fiq reset", {31'b0, fiq}, 32'd0);
    chk("R10 idle rvalid", {31'b0, bus_rvalid}, 32'd0);
    rd_chk("R1 src pend", 0, 32'h0);
    rd_chk("R1 mode", 1, 32'h0);
    rd_chk("R1 mask", 2, 32'hFFFF_FFFF);
    rd_chk("R1 prio", 3, 32'h7F);
    rd_chk("R1 insvc", 4, 32'h0);
    rd_chk("R1 index", 5, 32'h0);
    rd_chk("R1 sub pend", 6, 32'h0);
    rd_chk("R1 sub mask", 7, 32'h7FF);

    wr(2, 32'h0);
    wr(7, 32'h0);
    rd_chk("R2 mask replace", 2, 32'h0);

    // sweep every main line
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); src_req[i] = 1'b1;
      settle();
      rd_chk("R6 sweep insvc", 4, 32'd1 << i);
      rd_chk("R7 sweep index", 5, 32'(i));
      chk("R7 sweep irq high", {31'b0, irq}, 32'd1);
      @(negedge clk); src_req[i] = 1'b0;
      settle();
      rd_chk("R8 drop clears", 0, 32'h0);
      wr(4, 32'd1 << i);
      settle();
      chk("R2 R7 irq low after clear", {31'b0, irq}, 32'd0);
    end

    // level hold versus software clear
    @(negedge clk); src_level[4] = 1'b1; src_req[4] = 1'b1;
    settle();
    wr(0, 32'd1 << 4);
    settle();
    rd_chk("R8 level survives clear", 0, 32'd1 << 4);
    @(negedge clk); src_req[4] = 1'b0;
    settle();
    rd_chk("R8 level drop clears", 0, 32'h0);
    wr(4, 32'hFFFF_FFFF);
    @(negedge clk); src_level[4] = 1'b0;

    // edge line stays cleared while high
    @(negedge clk); src_req[4] = 1'b1;
    settle();
    wr(0, 32'd1 << 4);
    settle();
    rd_chk("R11 edge stays clear", 0, 32'h0);
    rd_chk("R6 insvc kept after src clear", 4, 32'd1 << 4);
    @(negedge clk); src_req[4] = 1'b0;
    wr(4, 32'hFFFF_FFFF);
    settle();

    // set and clear colliding on one bit
    @(negedge clk);
    src_req[9] = 1'b1;
    bus_wr = 1'b1; bus_addr = 5'd0; bus_wdata = 32'd1 << 9;
    @(negedge clk); bus_wr = 1'b0;
    settle();
    rd_chk("R9 set beats clear", 0, 32'd1 << 9);
    @(negedge clk); src_req[9] = 1'b0;
    settle();
    wr(4, 32'hFFFF_FFFF);
    settle();

    // replacement order
    @(negedge clk); src_req[5] = 1'b1; src_req[9] = 1'b1;
    settle();
    rd_chk("R6 lowest of two", 4, 32'd1 << 5);
    rd_chk("R6 index of two", 5, 32'd5);
    @(negedge clk); src_req[2] = 1'b1;
    settle();
    rd_chk("R6 lower replaces", 4, 32'd1 << 2);
    rd_chk("R6 lower index", 5, 32'd2);
    @(negedge clk); src_req[7] = 1'b1;
    settle();
    rd_chk("R6 higher does not replace", 4, 32'd1 << 2);
    wr(0, 32'd1 << 2);
    wr(4, 32'd1 << 2);
    settle();
    rd_chk("R6 next source after clear", 4, 32'd1 << 5);
    rd_chk("R6 next index", 5, 32'd5);
    @(negedge clk); src_req = '0;
    settle();
    wr(0, 32'hFFFF_FFFF);
    wr(4, 32'hFFFF_FFFF);
    settle();
    chk("R7 irq idle", {31'b0, irq}, 32'd0);

    // fast interrupt routing
    wr(1, 32'd1 << 3);
    rd_chk("R2 mode replace", 1, 32'd1 << 3);
    @(negedge clk); src_req[3] = 1'b1; src_req[6] = 1'b1;
    settle();
    chk("R5 fiq high", {31'b0, fiq}, 32'd1);
    rd_chk("R5 insvc frozen", 4, 32'h0);
    chk("R5 irq low", {31'b0, irq}, 32'd0);
    wr(2, 32'd1 << 3);
    settle();
    chk("R5 fiq low when masked", {31'b0, fiq}, 32'd0);
    rd_chk("R5 insvc after fiq", 4, 32'd1 << 6);
    @(negedge clk); src_req = '0;
    wr(2, 32'h0);
    wr(1, 32'h0);
    settle();
    wr(4, 32'hFFFF_FFFF);
    settle();

    // sub-source folding sweep
    for (int j = 0; j < SW; j++) begin
      @(negedge clk); sub_req[j] = 1'b1;
      settle();
      rd_chk("R4 sub pend", 6, 32'd1 << j);
      if (j < 9) begin
        rd_chk("R4 folded bit", 0, 32'd1 << tgt(j));
        rd_chk("R4 folded insvc", 4, 32'd1 << tgt(j));
      end else begin
        rd_chk("R4 no fold above 8", 0, 32'h0);
      end
      @(negedge clk); sub_req[j] = 1'b0;
      settle();
      rd_chk("R8 sub drop clears", 6, 32'h0);
      wr(0, 32'hFFFF_FFFF);
      wr(4, 32'hFFFF_FFFF);
      settle();
    end

    // sub mask blocks folding
    wr(7, 32'h1);
    @(negedge clk); sub_req[0] = 1'b1;
    settle();
    rd_chk("R4 masked sub pend", 6, 32'h1);
    rd_chk("R4 masked no fold", 0, 32'h0);
    @(negedge clk); sub_req[0] = 1'b0;
    settle();
    wr(7, 32'h0);
    settle();
    rd_chk("R4 still no fold", 0, 32'h0);

    // sub pending clear on write
    @(negedge clk); sub_req[10] = 1'b1;
    settle();
    wr(6, 32'd1 << 10);
    settle();
    rd_chk("R2 sub clear", 6, 32'h0);
    @(negedge clk); sub_req[10] = 1'b0;
    settle();

    // index is read-only; priority is plain storage
    wr(5, 32'h1F);
    rd_chk("R3 index ignores write", 5, 32'd15);
    wr(3, 32'h15);
    rd_chk("R2 prio replace", 3, 32'h15);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule